// File: doc/BRIEF.md
# Inclusive Second-Level Snoop Filter Controller

This block is the coherence bookkeeping and control logic of an inclusive second-level cache. It stands between the interconnect and a private write-back first-level cache. It is the only level that watches bus traffic. For every line it keeps a MESI-style coherence state (invalid, shared, exclusive, modified). It also keeps two per-line bits: one marks that the first-level cache holds a copy, and one marks that the copy there is newer than the second-level data. With these bits the block sends invalidations and data recalls to the first level only when a snoop or an eviction needs them.

Operations arrive one at a time on a single operation port. The port carries a kind code, a line index and an exclusivity flag. Snooped shared reads, snooped exclusive reads and second-level evictions are the tracked operations: each ends in a one-cycle response that reports whether the line was present and whether data leaves the cache. Line installs, first-level fill notices, first-level write-hit notices and first-level eviction notices update the line in the cycle they are taken and give no response. When a tracked operation needs the first level, the block raises a request carrying the line index and a request kind. It holds the request until the first level acknowledges, and only then gives the response.

The controller has three states. IDLE takes operations. L1_WAIT holds a first-level request. RESPOND gives the response and writes the final line state. The transitions are:
- IDLE to L1_WAIT on a tracked operation that needs the first level.
- IDLE to RESPOND on a tracked operation that does not.
- IDLE to IDLE on an untracked operation or when no operation is offered.
- L1_WAIT to RESPOND on acknowledge.
- L1_WAIT to L1_WAIT while no acknowledge arrives.
- RESPOND to IDLE always.

Top module: `l2_snoop_filter`

## Requirements
- R1: After reset every line is invalid with both tracking bits clear. In the first cycle after reset, `busy`, `l1_req_valid` and `done_valid` are 0.
- R2: Operation kind 3 (install) puts an invalid line into exclusive state when `op_excl` is 1 and into shared state when it is 0, with both bits clear. On a line that is already valid, the install is ignored.
- R3: Operation kind 4 (first-level fill) sets the line's in-first-level bit only when the line is valid. On an invalid line it is ignored, so the contents of the first level stay a subset of the second level.
- R4: Operation kind 5 (first-level write hit) moves the line to modified and sets its stale bit, but only when the in-first-level bit is set and the line is exclusive or modified. In every other case it is ignored.
- R5: Operation kind 0 (snooped shared read) on a line without the stale bit gives `done_valid` in the cycle after it is accepted. `done_hit` reports whether the line was valid and `done_flush` reports whether it was modified. An exclusive or modified line becomes shared.
- R6: A snooped shared read on a stale line first raises a first-level request of kind 2 (recall, keep copy). After the acknowledge it gives a response with flush set. The stale bit clears, the in-first-level bit stays set, and the line becomes shared.
- R7: Operation kind 1 (snooped exclusive read) on a line held by the first level raises a request of kind 0 (invalidate), or of kind 1 (invalidate with recall) if the line is stale, before responding. The response flushes when the line was modified, and the line becomes invalid with both bits clear.
- R8: Operation kind 2 (second-level eviction) back-invalidates a copy held by the first level in the same way as R7 before the line is replaced. The response flag `done_flush` marks a write-back of a modified line, and the line becomes invalid.
- R9: A first-level request keeps its kind and index stable until `l1_ack` is sampled high. `done_valid` rises in the cycle after that acknowledge and lasts exactly one cycle.
- R10: While `busy` is high, any offered operation is ignored.
- R11: Operation kind 6 (first-level eviction notice, data written back when stale) clears both the in-first-level bit and the stale bit, so a later snoop or eviction raises no first-level request.
- R12: A stale bit exists only on a modified line, and the in-first-level bit exists only on a valid line.
- R13: Operation kind 7 has no effect on any line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_kind | input | 3 | Operation kind code (0 to 7 as in the requirements) |
| op_idx | input | IDX_W | Line index of the operation |
| op_excl | input | 1 | Install in exclusive state (kind 3 only) |
| busy | output | 1 | A tracked operation is in progress; offered operations are ignored |
| l1_req_valid | output | 1 | Request to the first-level cache |
| l1_req_kind | output | 2 | 0 invalidate, 1 invalidate with recall, 2 recall and keep |
| l1_req_idx | output | IDX_W | Line index of the first-level request |
| l1_ack | input | 1 | First-level cache has completed the request |
| done_valid | output | 1 | One-cycle response of a tracked operation |
| done_hit | output | 1 | The line was valid when the operation was taken |
| done_flush | output | 1 | Modified data leaves the cache (snoop flush or write-back) |
| done_idx | output | IDX_W | Line index of the response |

## Verification
The assertions check on every cycle that each line seen by the controller obeys the ownership and inclusion rules: the stale bit appears only on modified lines and the in-first-level bit only on valid ones. They also check that a pending first-level request holds its kind and index, that a response follows an acknowledge one cycle later and lasts one cycle, and that the controller stays busy until its response. Only the bench scenarios can show that the right request kind is chosen for each mix of line state and bits, that ignored installs, fills, write hits and operations offered while busy leave lines unchanged, and that an eviction notice stops later recalls. The bench shows these by comparing responses and requests against a line-state model it keeps itself.

// File: rtl/l2sf_pkg.sv
package l2sf_pkg;

    typedef enum logic [1:0] {
        COH_I = 2'd0,
        COH_S = 2'd1,
        COH_E = 2'd2,
        COH_M = 2'd3
    } coh_t;

    typedef enum logic [2:0] {
        OP_SNP_RD   = 3'd0,
        OP_SNP_RDX  = 3'd1,
        OP_L2_EVICT = 3'd2,
        OP_L2_FILL  = 3'd3,
        OP_L1_FILL  = 3'd4,
        OP_L1_WRHIT = 3'd5,
        OP_L1_EVICT = 3'd6,
        OP_NONE     = 3'd7
    } op_t;

    typedef enum logic [1:0] {
        L1R_INV        = 2'd0,
        L1R_INV_RECALL = 2'd1,
        L1R_RECALL     = 2'd2
    } l1req_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_L1_WAIT = 2'd1,
        ST_RESPOND = 2'd2
    } fsm_t;

    typedef struct packed {
        coh_t coh;
        logic in_l1;
        logic stale;
    } line_t;

    localparam line_t LINE_EMPTY = '{coh: COH_I, in_l1: 1'b0, stale: 1'b0};

endpackage

// File: rtl/l2sf_line_table.sv
module l2sf_line_table
    import l2sf_pkg::*;
#(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  line_t            wdata,
    output line_t            rdata
);

    line_t mem [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                mem[i] <= LINE_EMPTY;
            end
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/l2sf_action_decode.sv
module l2sf_action_decode
    import l2sf_pkg::*;
(
    input  op_t    kind,
    input  logic   excl,
    input  line_t  cur,
    output logic   tracked,
    output line_t  imm_line,
    output logic   need_l1,
    output l1req_t l1_kind,
    output line_t  resp_line,
    output logic   hit,
    output logic   flush
);

    always_comb begin
        tracked   = 1'b0;
        imm_line  = cur;
        need_l1   = 1'b0;
        l1_kind   = L1R_INV;
        resp_line = cur;
        hit       = (cur.coh != COH_I);
        flush     = (cur.coh == COH_M);
        unique case (kind)
            OP_SNP_RD: begin
                tracked = 1'b1;
                need_l1 = cur.stale;
                l1_kind = L1R_RECALL;
                if (cur.coh != COH_I) begin
                    resp_line.coh = COH_S;
                end
            end
            OP_SNP_RDX, OP_L2_EVICT: begin
                tracked   = 1'b1;
                need_l1   = cur.in_l1;
                l1_kind   = cur.stale ? L1R_INV_RECALL : L1R_INV;
                resp_line = LINE_EMPTY;
            end
            OP_L2_FILL: begin
                if (cur.coh == COH_I) begin
                    imm_line     = LINE_EMPTY;
                    imm_line.coh = excl ? COH_E : COH_S;
                end
            end
            OP_L1_FILL: begin
                if (cur.coh != COH_I) begin
                    imm_line.in_l1 = 1'b1;
                end
            end
            OP_L1_WRHIT: begin
                if (cur.in_l1 && (cur.coh == COH_E || cur.coh == COH_M)) begin
                    imm_line.coh   = COH_M;
                    imm_line.stale = 1'b1;
                end
            end
            OP_L1_EVICT: begin
                imm_line.in_l1 = 1'b0;
                imm_line.stale = 1'b0;
            end
            OP_NONE: begin
            end
        endcase
    end

endmodule

// File: rtl/l2_snoop_filter.sv
module l2_snoop_filter
    import l2sf_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_kind,
    input  logic [IDX_W-1:0] op_idx,
    input  logic             op_excl,
    output logic             busy,
    output logic             l1_req_valid,
    output logic [1:0]       l1_req_kind,
    output logic [IDX_W-1:0] l1_req_idx,
    input  logic             l1_ack,
    output logic             done_valid,
    output logic             done_hit,
    output logic             done_flush,
    output logic [IDX_W-1:0] done_idx
);

    fsm_t             st, st_nxt;
    op_t              cur_kind;
    logic [IDX_W-1:0] cur_idx;
    l1req_t           req_kind;

    logic             accept;
    logic [IDX_W-1:0] line_idx;
    op_t              dec_kind;
    line_t            rd_line, wr_line;
    logic             wr_en;

    logic             tracked, need_l1, hit, flush;
    l1req_t           l1_kind;
    line_t            imm_line, resp_line;

    assign accept   = (st == ST_IDLE) && op_valid;
    assign line_idx = (st == ST_IDLE) ? op_idx : cur_idx;
    assign dec_kind = (st == ST_IDLE) ? op_t'(op_kind) : cur_kind;

    l2sf_line_table #(.LINES(LINES), .IDX_W(IDX_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .idx   (line_idx),
        .wdata (wr_line),
        .rdata (rd_line)
    );

    l2sf_action_decode u_decode (
        .kind      (dec_kind),
        .excl      (op_excl),
        .cur       (rd_line),
        .tracked   (tracked),
        .imm_line  (imm_line),
        .need_l1   (need_l1),
        .l1_kind   (l1_kind),
        .resp_line (resp_line),
        .hit       (hit),
        .flush     (flush)
    );

    // Next state and line-table write
    always_comb begin
        st_nxt  = st;
        wr_en   = 1'b0;
        wr_line = rd_line;
        unique case (st)
            ST_IDLE: begin
                if (accept) begin
                    if (tracked) begin
                        st_nxt = need_l1 ? ST_L1_WAIT : ST_RESPOND;
                    end else begin
                        wr_en   = 1'b1;
                        wr_line = imm_line;
                    end
                end
            end
            ST_L1_WAIT: begin
                if (l1_ack) begin
                    st_nxt        = ST_RESPOND;
                    wr_en         = 1'b1;
                    wr_line.stale = 1'b0;
                    if (req_kind != L1R_RECALL) begin
                        wr_line.in_l1 = 1'b0;
                    end
                end
            end
            ST_RESPOND: begin
                st_nxt  = ST_IDLE;
                wr_en   = 1'b1;
                wr_line = resp_line;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Captured operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind <= OP_NONE;
            cur_idx  <= '0;
            req_kind <= L1R_INV;
        end else if (accept) begin
            cur_kind <= op_t'(op_kind);
            cur_idx  <= op_idx;
            req_kind <= l1_kind;
        end
    end

    // Outputs
    always_comb begin
        busy         = (st != ST_IDLE);
        l1_req_valid = (st == ST_L1_WAIT);
        l1_req_kind  = req_kind;
        l1_req_idx   = cur_idx;
        done_valid   = (st == ST_RESPOND);
        done_hit     = done_valid && hit;
        done_flush   = done_valid && flush;
        done_idx     = cur_idx;
    end

endmodule

// File: rtl/l2sf_checker.sv
module l2sf_checker
    import l2sf_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             l1_req_valid,
    input logic [1:0]       l1_req_kind,
    input logic [IDX_W-1:0] l1_req_idx,
    input logic             l1_ack,
    input logic             done_valid,
    input line_t            rd_line
);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        l1_req_valid && !l1_ack |=> l1_req_valid && $stable(l1_req_kind) && $stable(l1_req_idx));

    p_ack_then_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        l1_req_valid && l1_ack |=> done_valid && !l1_req_valid);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid && !busy);

    p_req_kind_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        l1_req_valid |-> l1_req_kind != 2'd3);

    p_busy_until_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done_valid |=> busy);

    p_stale_owned_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_line.stale |-> rd_line.coh == COH_M);

    p_inclusion_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_line.in_l1 |-> rd_line.coh != COH_I);

endmodule

bind l2_snoop_filter l2sf_checker #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .l1_req_valid (l1_req_valid),
    .l1_req_kind  (l1_req_kind),
    .l1_req_idx   (l1_req_idx),
    .l1_ack       (l1_ack),
    .done_valid   (done_valid),
    .rd_line      (rd_line)
);

// File: tb/l2_snoop_filter_test.sv
module l2_snoop_filter_test;

    localparam int LINES = 16;
    localparam int IW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_kind = 3'd7;
    logic [IW-1:0] op_idx = '0;
    logic          op_excl = 1'b0;
    logic          busy, l1_req_valid, done_valid, done_hit, done_flush;
    logic [1:0]    l1_req_kind;
    logic [IW-1:0] l1_req_idx, done_idx;
    logic          l1_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    // model: coherence 0 I, 1 S, 2 E, 3 M
    int m_coh [LINES];
    bit m_in  [LINES];
    bit m_st  [LINES];

    always #5 clk = ~clk;

    l2_snoop_filter #(.LINES(LINES)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_idx(op_idx), .op_excl(op_excl), .busy(busy),
        .l1_req_valid(l1_req_valid), .l1_req_kind(l1_req_kind),
        .l1_req_idx(l1_req_idx), .l1_ack(l1_ack), .done_valid(done_valid),
        .done_hit(done_hit), .done_flush(done_flush), .done_idx(done_idx)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(int kind);
        case (kind)
            0: return "R5";
            1: return "R7";
            2: return "R8";
            3: return "R2";
            4: return "R3";
            5: return "R4";
            6: return "R11";
            default: return "R13";
        endcase
    endfunction

    function automatic void model_apply(int kind, int idx, bit excl);
        case (kind)
            0: begin if (m_coh[idx] != 0) m_coh[idx] = 1; m_st[idx] = 0; end
            1, 2: begin m_coh[idx] = 0; m_in[idx] = 0; m_st[idx] = 0; end
            3: if (m_coh[idx] == 0) m_coh[idx] = excl ? 2 : 1;
            4: if (m_coh[idx] != 0) m_in[idx] = 1;
            5: if (m_in[idx] && m_coh[idx] >= 2) begin m_coh[idx] = 3; m_st[idx] = 1; end
            6: begin m_in[idx] = 0; m_st[idx] = 0; end
            default: ;
        endcase
    endfunction

    // intrude: offer an install on intr_idx while the L1 request waits
    task automatic run_op(int kind, int idx, bit excl, int delay, bit intrude, int intr_idx);
        bit tracked  = (kind <= 2);
        bit need     = (kind == 0) ? m_st[idx] : m_in[idx];
        int rkind    = (kind == 0) ? 2 : (m_st[idx] ? 1 : 0);
        int ehit     = (m_coh[idx] != 0);
        int eflush   = (m_coh[idx] == 3);
        string rq    = (kind == 0 && need) ? "R6" : req_of(kind);
        @(negedge clk);
        op_valid = 1'b1; op_kind = 3'(kind); op_idx = IW'(idx); op_excl = excl;
        @(negedge clk);
        op_valid = 1'b0; op_kind = 3'd7;
        if (!tracked) begin
            check_eq(rq, "busy after untracked op", busy, 0);
        end else begin
            if (need) begin
                check_eq(rq, "l1_req_valid", l1_req_valid, 1);
                check_eq(rq, "l1_req_kind", l1_req_kind, rkind);
                check_eq(rq, "l1_req_idx", l1_req_idx, idx);
                for (int d = 0; d < delay; d++) begin
                    if (intrude) begin
                        op_valid = 1'b1; op_kind = 3'd3; op_idx = IW'(intr_idx); op_excl = 1'b1;
                    end
                    @(negedge clk);
                    check_eq("R9", "request held", l1_req_valid, 1);
                    check_eq("R9", "kind held", l1_req_kind, rkind);
                    check_eq("R9", "no early response", done_valid, 0);
                end
                op_valid = 1'b0; op_kind = 3'd7;
                l1_ack = 1'b1;
                @(negedge clk);
                l1_ack = 1'b0;
            end else begin
                check_eq(rq, "no l1 request", l1_req_valid, 0);
            end
            check_eq(rq, "done_valid", done_valid, 1);
            check_eq(rq, "done_hit", done_hit, ehit);
            check_eq(rq, "done_flush", done_flush, eflush);
            check_eq(rq, "done_idx", done_idx, idx);
        end
        model_apply(kind, idx, excl);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin m_coh[i] = 0; m_in[i] = 0; m_st[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_eq("R1", "busy", busy, 0);
        check_eq("R1", "l1_req_valid", l1_req_valid, 0);
        check_eq("R1", "done_valid", done_valid, 0);
        run_op(0, 0, 0, 0, 0, 0);        // R1: line empty, no hit
        run_op(2, 9, 0, 0, 0, 0);

        // R3: first-level fill on invalid line ignored
        run_op(4, 1, 0, 0, 0, 0);
        run_op(2, 1, 0, 0, 0, 0);

        // R4, R6, R7: exclusive line, write hit, recall on shared read
        run_op(3, 2, 1, 0, 0, 0);
        run_op(4, 2, 0, 0, 0, 0);
        run_op(5, 2, 0, 0, 0, 0);
        run_op(0, 2, 0, 2, 0, 0);
        run_op(1, 2, 0, 1, 0, 0);

        // R4: write hit on shared line ignored
        run_op(3, 3, 0, 0, 0, 0);
        run_op(4, 3, 0, 0, 0, 0);
        run_op(5, 3, 0, 0, 0, 0);
        run_op(1, 3, 0, 0, 0, 0);

        // R2, R7, R10: second install ignored; intrusion while busy ignored
        run_op(3, 4, 1, 0, 0, 0);
        run_op(3, 4, 0, 0, 0, 0);
        run_op(4, 4, 0, 0, 0, 0);
        run_op(5, 4, 0, 0, 0, 0);
        run_op(1, 4, 0, 3, 1, 5);
        run_op(0, 5, 0, 0, 0, 0);        // R10: line 5 still invalid

        // R11, R8: eviction notice stops back-invalidate; write-back of M
        run_op(3, 6, 1, 0, 0, 0);
        run_op(4, 6, 0, 0, 0, 0);
        run_op(5, 6, 0, 0, 0, 0);
        run_op(6, 6, 0, 0, 0, 0);
        run_op(2, 6, 0, 0, 0, 0);

        // R8: eviction back-invalidates clean L1 copy
        run_op(3, 7, 0, 0, 0, 0);
        run_op(4, 7, 0, 0, 0, 0);
        run_op(2, 7, 0, 2, 0, 0);

        // R13 and R5: unused code ignored; exclusive line downgraded by read
        run_op(3, 8, 1, 0, 0, 0);
        run_op(7, 8, 0, 0, 0, 0);
        run_op(0, 8, 0, 0, 0, 0);
        run_op(4, 8, 0, 0, 0, 0);
        run_op(5, 8, 0, 0, 0, 0);        // R4: now shared, ignored
        run_op(1, 8, 0, 0, 0, 0);

        // constrained random
        begin
            int unsigned seed = 32'd2024;
            void'($urandom(seed));
        end
        for (int n = 0; n < 600; n++) begin
            int r    = int'($urandom_range(0, 15));
            int kind = (r < 8) ? (r % 7) : ((r < 11) ? 3 : ((r < 13) ? 4 : 5));
            int idx  = int'($urandom_range(0, 7));
            bit ex   = 1'($urandom_range(0, 1));
            int dly  = int'($urandom_range(0, 3));
            run_op(kind, idx, ex, dly, 0, 0);
        end
        @(negedge clk);
        check_eq("R9", "idle at end", busy, 0);
        finish_run();
    end

endmodule